// File: doc/BRIEF.md
# SPI Flash Slave Serial Front End

This block is the pin-side engine of a serial flash device. It turns the bit stream that arrives on the data-in line into whole bytes for the command logic behind it, and it turns the bytes that the command logic hands back into a bit stream on the data-out line. Chip select frames every instruction. A pause line lets the bus master freeze a transfer part-way through a byte and resume it later without deselecting the device.

All four bus pins are brought into the block's own clock domain through a short synchronizer chain, and every bus edge is detected there. The command logic sees a one-cycle byte strobe with the byte and its position in the frame. It is asked for the next outgoing byte on the serial-clock falling edge that opens each byte slot, and answers in that same cycle with a byte and a valid flag. The data-out pin is given as a value plus an output enable, so the pad ring builds the tri-state driver.

Top module: `spi_flash_fe`

## Requirements
- R1: Once reset is released with chip select high, `so_oe`, `rx_valid`, `tx_req` and `frame_start` are all low.
- R2: While chip select is low, `si` is sampled on each rising serial-clock edge. After eight such edges `rx_valid` is high for exactly one cycle, and `rx_byte` then holds the eight bits with the first one received in bit 7.
- R3: Frames that begin with the serial clock idling low (mode 0) and frames that begin with it idling high (mode 3) yield the same received bytes and the same output bits.
- R4: A falling chip-select edge pulses `frame_start` for one cycle. `rx_index` is 0 with the first byte of a frame and rises by one with each later byte. It stops at INDEX_MAX (default 7) and stays there until the next frame.
- R5: A rising chip-select edge before the eighth bit of a byte drops that byte without a strobe. The next frame starts again at bit 0 and index 0.
- R6: `tx_req` pulses on every serial-clock falling edge that falls on a byte boundary of the frame (bit count 0), and `tx_byte`/`tx_valid` are taken in that cycle. The byte is sent most significant bit first, and `so_data` changes only after falling edges. In a frame of N bytes, mode 0 with the clock returned low before deselect and mode 3 both produce N requests.
- R7: `so_oe` is low whenever chip select is high, and for a whole byte slot whose request was answered with `tx_valid` low (for example the first slot of each frame).
- R8: With chip select low, the pause takes effect in the first cycle where the pause line is low and the serial clock is low, and it ends in the first cycle where both are high and low respectively. A falling clock edge that starts the pause still shifts the output. While paused, `so_oe` is low and clock edges and `si` have no effect. After the pause the byte continues at the same bit position.
- R9: Raising chip select while paused ends the pause and clears the serial state. The next frame captures from bit 0 and index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, well above the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause request |
| si | input | 1 | Serial data in |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the data-out pad; low means high impedance |
| frame_start | output | 1 | One-cycle pulse when a frame opens |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last received byte, held between strobes |
| rx_index | output | $clog2(INDEX_MAX+1) | Position of that byte in the frame, saturating |
| tx_req | output | 1 | Request for the byte of the slot now opening |
| tx_byte | input | 8 | Byte supplied in answer to `tx_req` |
| tx_valid | input | 1 | High if `tx_byte` is to be driven for that slot |

## Verification
Each pin change reaches the edge detectors two block cycles later. The resulting strobe, request, output bit or enable appears one cycle after that, so a result follows its bus edge by about three cycles. The bench holds every serial-clock phase for eight block cycles and samples the data-out value and enable at the end of a low phase, just before it raises the clock, the way a master would. Received bytes are pushed into a queue with their expected index before their bits are driven, and are popped when the strobe shows up, whatever the exact cycle. Request counts and stray strobes are checked once each frame has been deselected.

// File: rtl/spi_flash_fe_pkg.sv
package spi_flash_fe_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  // Bus pins as they arrive, in one packed bundle for the synchronizer.
  typedef struct packed {
    logic sck;
    logic cs_n;
    logic hold_n;
    logic si;
  } pin_t;

  localparam int   PIN_W    = $bits(pin_t);
  // Idle pin levels loaded into the synchronizer during reset.
  localparam pin_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1, si: 1'b0};

endpackage

// File: rtl/spi_flash_fe_sync.sv
module spi_flash_fe_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      logic [STAGES-1:0][W-1:0] stg_d;
      always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_flash_fe_hold.sv
module spi_flash_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sck_lvl,
  input  logic hold_n_lvl,
  output logic hold_q
);

  logic hold_d;

  // The pause line is only looked at while the clock is low, which
  // defers both entry and exit to the next low phase of the clock.
  always_comb begin
    hold_d = hold_q;
    if (!cs_act)       hold_d = 1'b0;
    else if (!sck_lvl) hold_d = ~hold_n_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

endmodule

// File: rtl/spi_flash_fe_rx.sv
module spi_flash_fe_rx
  import spi_flash_fe_pkg::*;
#(
  parameter int INDEX_MAX = 7,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              si_lvl,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [IDX_W-1:0]  rx_index
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(INDEX_MAX);

  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-2:0] acc_q, acc_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    bit_d  = bit_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    byte_d = byte_q;
    idx_d  = idx_q;
    if (clear) begin
      bit_d = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      bit_d = bit_q + 1'b1;
      acc_d = {acc_q[BYTE_W-3:0], si_lvl};
      if (bit_q == BIT_LAST) begin
        vld_d  = 1'b1;
        byte_d = {acc_q, si_lvl};
        idx_d  = cnt_q;
        if (cnt_q != IDX_TOP) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
      idx_q  <= '0;
    end else begin
      bit_q  <= bit_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      byte_q <= byte_d;
      idx_q  <= idx_d;
    end
  end

  assign bit_cnt  = bit_q;
  assign rx_valid = vld_q;
  assign rx_byte  = byte_q;
  assign rx_index = idx_q;

endmodule

// File: rtl/spi_flash_fe_tx.sv
module spi_flash_fe_tx
  import spi_flash_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fall_en,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_req,
  output logic              so_bit,
  output logic              loaded
);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              act_q, act_d;
  logic              boundary;

  assign boundary = (bit_cnt == '0);
  assign tx_req   = fall_en & boundary;

  // The answer to a request is taken straight into the shifter.
  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    if (clear) begin
      act_d = 1'b0;
    end else if (fall_en) begin
      if (boundary) begin
        sh_d  = tx_byte;
        act_d = tx_valid;
      end else begin
        sh_d = {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign so_bit = sh_q[BYTE_W-1];
  assign loaded = act_q;

endmodule

// File: rtl/spi_flash_fe.sv
module spi_flash_fe
  import spi_flash_fe_pkg::*;
#(
  parameter int  INDEX_MAX   = 7,
  parameter int  SYNC_STAGES = 2,
  localparam int IDX_W       = (INDEX_MAX < 1) ? 1 : $clog2(INDEX_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  output logic              so_data,
  output logic              so_oe,
  output logic              frame_start,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [IDX_W-1:0]  rx_index,
  output logic              tx_req,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid
);

  pin_t pins_raw;
  pin_t pins_s;

  assign pins_raw = '{sck: sck, cs_n: cs_n, hold_n: hold_n, si: si};

  spi_flash_fe_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic sck_lvl, cs_act;
  logic sck_p, cs_act_p;
  logic sck_rise, sck_fall;
  logic hold_q, run;
  logic [BIT_W-1:0] bit_cnt;
  logic so_bit, loaded;

  assign sck_lvl = pins_s.sck;
  assign cs_act  = ~pins_s.cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= 1'b0;
      cs_act_p <= 1'b0;
    end else begin
      sck_p    <= sck_lvl;
      cs_act_p <= cs_act;
    end
  end

  assign sck_rise    = sck_lvl & ~sck_p;
  assign sck_fall    = ~sck_lvl & sck_p;
  assign frame_start = cs_act & ~cs_act_p;
  // Edges count only while selected and not paused (registered pause state).
  assign run         = cs_act & ~hold_q;

  spi_flash_fe_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sck_lvl    (sck_lvl),
    .hold_n_lvl (pins_s.hold_n),
    .hold_q     (hold_q)
  );

  spi_flash_fe_rx #(
    .INDEX_MAX (INDEX_MAX),
    .IDX_W     (IDX_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~cs_act),
    .shift_en (run & sck_rise),
    .si_lvl   (pins_s.si),
    .bit_cnt  (bit_cnt),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_index (rx_index)
  );

  spi_flash_fe_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~cs_act),
    .fall_en  (run & sck_fall),
    .bit_cnt  (bit_cnt),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid),
    .tx_req   (tx_req),
    .so_bit   (so_bit),
    .loaded   (loaded)
  );

  assign so_data = so_bit;
  assign so_oe   = cs_act & ~hold_q & loaded;

endmodule

// File: rtl/spi_flash_fe_chk.sv
module spi_flash_fe_chk
  import spi_flash_fe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             sck_lvl,
  input logic             hold_q,
  input logic [BIT_W-1:0] bit_cnt,
  input logic             rx_valid,
  input logic             so_oe
);

  // R2: a received-byte strobe lasts one cycle
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: a newly opened frame always starts at bit 0
  p_frame_bit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !$past(cs_act)) |-> (bit_cnt == '0));

  // R7: no drive on the data-out pad while deselected
  p_oe_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !so_oe);

  // R8: the pad is released for the whole pause
  p_quiet_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !so_oe);

  // R8: no byte completes while paused
  p_no_capture_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !rx_valid);

  // R8: the pause state changes only in a clock-low cycle, or on deselect (R9)
  p_hold_moves_sck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != $past(hold_q)) |-> (!$past(sck_lvl) || !$past(cs_act)));

endmodule

bind spi_flash_fe spi_flash_fe_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .sck_lvl  (sck_lvl),
  .hold_q   (hold_q),
  .bit_cnt  (bit_cnt),
  .rx_valid (rx_valid),
  .so_oe    (so_oe)
);

// File: tb/spi_flash_fe_test.sv
module spi_flash_fe_test;

  localparam int IMAX = 7;
  localparam int IW   = $clog2(IMAX + 1);
  localparam int H    = 8;

  logic          clk, rst_n, sck, cs_n, hold_n, si;
  logic          so_data, so_oe, frame_start, rx_valid, tx_req, tx_valid;
  logic [7:0]    rx_byte, tx_byte;
  logic [IW-1:0] rx_index;

  int  checks = 0, errors = 0;
  bit  done = 0;
  bit  resp_en = 0;
  logic seen;
  int  slot, prev_idx, req_cnt = 0, fs_cnt = 0, frames = 0;
  logic [7:0] prev_b;
  logic [IW+7:0] expq[$];

  spi_flash_fe #(.INDEX_MAX(IMAX), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so_data(so_data), .so_oe(so_oe), .frame_start(frame_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_index(rx_index),
    .tx_req(tx_req), .tx_byte(tx_byte), .tx_valid(tx_valid)
  );

  initial begin clk = 0; forever #10 clk = ~clk; end

  // Command-logic stand-in: answers with a byte derived from the last capture.
  always @(posedge clk) begin
    if (!rst_n || frame_start) seen <= 1'b0;
    else if (rx_valid)         seen <= 1'b1;
  end
  assign tx_valid = resp_en & seen;
  assign tx_byte  = ~rx_byte + 8'(rx_index);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tx_req) req_cnt++;
      if (frame_start) fs_cnt++;
      if (rx_valid) begin
        if (expq.size() == 0) check("R5 unexpected byte strobe", 1, 0);
        else begin
          logic [IW+7:0] e;
          e = expq.pop_front();
          check("R2 received byte", rx_byte, e[7:0]);
          check("R4 byte index", rx_index, e[IW+7:8]);
        end
      end
    end
  end

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic s, output logic o);
    sck = 0; si = b;
    wait_h();
    o = so_oe; s = so_data;
    sck = 1;
    wait_h();
  endtask

  task automatic do_hold(input bit def_in, input bit def_out);
    logic oe_seen;
    oe_seen = 0;
    if (def_in) begin hold_n = 0; wait_h(); sck = 0; wait_h(); end
    else        begin sck = 0; wait_h(); hold_n = 0; wait_h(); end
    oe_seen = oe_seen | so_oe;
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1; wait_h(); oe_seen = oe_seen | so_oe;
      sck = 0; wait_h(); oe_seen = oe_seen | so_oe;
    end
    check("R8 so_oe low during pause", oe_seen, 0);
    if (def_out) begin sck = 1; wait_h(); hold_n = 1; wait_h(); sck = 0; wait_h(); end
    else         begin hold_n = 1; wait_h(); end
  endtask

  task automatic send_byte(input logic [7:0] b, input int hold_bit = -1,
                           input bit def_in = 0, input bit def_out = 0);
    logic [7:0] got, oes;
    logic s, o;
    int idx;
    idx = (slot < IMAX) ? slot : IMAX;
    expq.push_back({IW'(idx), b});
    for (int i = 7; i >= 0; i--) begin
      put_bit(b[i], s, o);
      got[i] = s; oes[i] = o;
      if (i == hold_bit) do_hold(def_in, def_out);
    end
    if (resp_en && slot >= 1) begin
      check("R7 so_oe on for answered slot", oes, 8'hFF);
      check("R6 serial output byte", got, 8'(~prev_b + 8'(prev_idx)));
    end else begin
      check("R7 so_oe off for unanswered slot", oes, 8'h00);
    end
    prev_b = b; prev_idx = idx; slot++;
  endtask

  task automatic start_frame(input bit mode3);
    sck = mode3; wait_h();
    slot = 0; req_cnt = 0; frames++;
    cs_n = 0; wait_h();
  endtask

  task automatic end_frame(input bit mode3, input int nbytes, input bit chk);
    if (!mode3) begin sck = 0; wait_h(); end
    cs_n = 1; wait_h(); wait_h();
    if (chk) check("R6 tx_req count per frame", req_cnt, nbytes);
    check("R7 so_oe low when deselected", so_oe, 0);
  endtask

  initial begin
    logic s, o;
    rst_n = 0; cs_n = 1; sck = 0; hold_n = 1; si = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 so_oe after reset", so_oe, 0);
    check("R1 rx_valid after reset", rx_valid, 0);
    check("R1 tx_req after reset", tx_req, 0);
    check("R1 frame_start after reset", frame_start, 0);

    // R2/R7: mode 0, no answers
    start_frame(0);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h01);
    end_frame(0, 3, 1);

    // R6: mode 0 with answers
    resp_en = 1;
    start_frame(0);
    send_byte(8'h05); send_byte(8'h80); send_byte(8'h7E); send_byte(8'hFF);
    end_frame(0, 4, 1);

    // R3: same traffic in mode 3
    start_frame(1);
    send_byte(8'h05); send_byte(8'h80); send_byte(8'h7E); send_byte(8'hFF);
    end_frame(1, 4, 1);

    // R4: long frame, index saturates
    start_frame(0);
    for (int n = 0; n < 11; n++) send_byte(8'(n * 37 + 11));
    end_frame(0, 11, 1);

    // R5: deselect part-way through a byte, then a clean frame
    start_frame(1);
    send_byte(8'h9C);
    for (int i = 0; i < 5; i++) put_bit(1'b1, s, o);
    end_frame(1, 0, 0);
    start_frame(0);
    send_byte(8'h66); send_byte(8'h99);
    end_frame(0, 2, 1);

    // R8: pauses with deferred and immediate entry and exit
    start_frame(0);
    send_byte(8'h12);
    send_byte(8'hB7, 4, 1, 1);
    send_byte(8'h4D, 2, 0, 0);
    send_byte(8'hE1, 5, 1, 0);
    end_frame(0, 4, 1);
    start_frame(1);
    send_byte(8'h3A);
    send_byte(8'hC5, 3, 0, 1);
    end_frame(1, 2, 1);

    // R9: deselect while paused, then a fresh frame
    start_frame(0);
    send_byte(8'hC3);
    for (int i = 0; i < 3; i++) put_bit(1'b0, s, o);
    sck = 0; wait_h(); hold_n = 0; wait_h();
    check("R9 so_oe low while paused", so_oe, 0);
    cs_n = 1; wait_h(); wait_h();
    hold_n = 1; wait_h();
    start_frame(0);
    send_byte(8'h5A); send_byte(8'hA6);
    end_frame(0, 2, 1);

    wait_h();
    check("R5 no stray or missing strobes", expq.size(), 0);
    check("R4 frame_start count", fs_cnt, frames);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule